// File: doc/BRIEF.md
# Host-Bridge CPU Address Decoder

The decoder sits between a 32-bit processor bus and the PCI side of a host bridge. Every access presented on the request port is sorted into one region: general PCI I/O, a direct configuration window, PCI memory, a single-byte interrupt-acknowledge location, or the boot ROM. The decoder returns the translated downstream address and a region code one clock later. Accesses that match no region, or that carry an illegal size, are flagged as decode errors.

I/O offsets in the low 8 MB are folded into a 16-bit port address by one of two schemes. A mode input picks the scheme. In the flat scheme the low 16 offset bits are kept. In the sparse scheme, each 4 KB CPU page carries 32 ports. The configuration window turns the lowest set bit of a select field into a device number. The block also keeps the 32-bit configuration index register and turns data-port accesses into addresses built from that index.

Top module: `hb_addr_decoder`

## Requirements
- R1: After reset, rsp_valid, rsp_err, rsp_region, rsp_addr and rsp_rdata are all 0, the configuration index is 0 and the flat I/O scheme is in use.
- R2: A request accepted on a clock edge produces its response on the next edge (rsp_valid high for one cycle). On idle cycles rsp_region is 0 and rsp_err is low. The region codes are: 0 none, 1 I/O, 2 config window, 3 memory, 4 interrupt-acknowledge, 5 ROM, 6 config data port, 7 config index register.
- R3: Addresses 0x80800000 to 0x80BFFFFF give region 2, ahead of the I/O decode. Offset bits 11 to 21 are scanned upward. The position of the first set bit (0 to 10), or 11 if none is set, is placed at bit 11 of rsp_addr, and offset bits [10:0] are kept.
- R4: The remaining addresses from 0x80000000 to 0xBF7FFFFF give I/O. With io_mode sampled low and an offset below 0x800000, the port address is offset[15:0].
- R5: With io_mode sampled high and an offset below 0x800000, the port address is {offset[22:12], offset[4:0]} in bits [15:0]. I/O offsets of 0x800000 and above pass through unchanged in either mode.
- R6: io_mode is captured only on clock edges where req_valid is low. A change while requests run back to back has no effect until an idle edge.
- R7: 0xC0000000 to 0xFEFFFFFF give region 3, with address = CPU address − 0xC0000000.
- R8: 0xFFF00000 to 0xFFFFFFFF give region 5, with address = CPU address − 0xFFF00000.
- R9: A 1-byte read at 0xBFFFFFF0 gives region 4 with address 0. A wider read there is a decode error. A write there gives region 0 with no error.
- R10: An I/O access whose port address is 0xCF8 to 0xCFB reaches the index register (region 7). Byte lane k of the data bus maps to index byte (port[1:0]+k), little-endian. Lanes beyond byte 3 are dropped. Reads return the selected bytes in rsp_rdata; writes return 0.
- R11: An I/O access whose port address is 0xCFC to 0xCFF gives region 6, with address = {index[31:2], port[1:0]}.
- R12: A size code of 3 (codes: 0 = 1 byte, 1 = 2, 2 = 4), or an address outside every region, raises rsp_err for that one response. rsp_rdata is then all ones, and region and address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | CPU byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| io_mode | input | 1 | 0 = flat I/O scheme, 1 = sparse I/O scheme |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_region | output | 3 | Region code |
| rsp_addr | output | 32 | Translated downstream address |
| rsp_err | output | 1 | Decode error |
| rsp_rdata | output | 32 | Index read data or all-ones on error |

## Verification
Two functions can meet in one edge: an index-register write and a data-port access that follows it with no idle cycle between. The bench issues such a pair back to back and expects the data-port address to carry the index just written. A mode change and a running request can also coincide. The bench flips io_mode in the middle of a back-to-back burst and expects every access in that burst to keep the scheme captured at the last idle edge, with the new scheme applying only after one idle edge.

// File: rtl/hb_dec_pkg.sv
`timescale 1ns/1ps
// Shared types for the host-bridge address decoder.
// Assumes a 3-bit region code carried on the top-level port.
package hb_dec_pkg;
    typedef enum logic [2:0] {
        RGN_NONE    = 3'd0,
        RGN_IO      = 3'd1,
        RGN_CFG     = 3'd2,
        RGN_MEM     = 3'd3,
        RGN_IACK    = 3'd4,
        RGN_ROM     = 3'd5,
        RGN_CFGDATA = 3'd6,
        RGN_CFGIDX  = 3'd7
    } region_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_BAD  = 2'd3;
endpackage

// File: rtl/hb_region_classify.sv
`timescale 1ns/1ps
// Sorts a CPU address into a raw region and gives the offset from that
// region's base. The config window is tested before general I/O.
// Assumes all windows are naturally placed as given by the parameters.
module hb_region_classify
    import hb_dec_pkg::*;
#(
    parameter logic [31:0] IO_BASE   = 32'h8000_0000,
    parameter logic [31:0] IO_SIZE   = 32'h3F80_0000,
    parameter logic [31:0] CFG_BASE  = 32'h8080_0000,
    parameter int          CFG_LOG2  = 22,
    parameter logic [31:0] MEM_BASE  = 32'hC000_0000,
    parameter logic [31:0] MEM_SIZE  = 32'h3F00_0000,
    parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0,
    parameter int          ROM_LOG2  = 20
) (
    input  logic [31:0] addr,
    output region_e     cls,
    output logic [31:0] off
);
    localparam logic [31:0] CFG_TAG  = CFG_BASE >> CFG_LOG2;
    localparam logic [31:0] ROM_BASE = ~((32'h1 << ROM_LOG2) - 32'h1);
    localparam logic [31:0] ROM_TAG  = ROM_BASE >> ROM_LOG2;

    // Priority decode of the address into one region.
    always_comb begin
        cls = RGN_NONE;
        off = 32'h0;
        if ((addr >> CFG_LOG2) == CFG_TAG) begin
            cls = RGN_CFG;
            off = addr - CFG_BASE;
        end else if (addr >= IO_BASE && (addr - IO_BASE) < IO_SIZE) begin
            cls = RGN_IO;
            off = addr - IO_BASE;
        end else if (addr == IACK_ADDR) begin
            cls = RGN_IACK;
        end else if (addr >= MEM_BASE && (addr - MEM_BASE) < MEM_SIZE) begin
            cls = RGN_MEM;
            off = addr - MEM_BASE;
        end else if ((addr >> ROM_LOG2) == ROM_TAG) begin
            cls = RGN_ROM;
            off = addr - ROM_BASE;
        end
    end
endmodule

// File: rtl/hb_io_xlate.sv
`timescale 1ns/1ps
// Folds an I/O offset into a port address. Offsets inside the low window
// use the flat or the sparse scheme. Offsets above it pass unchanged.
// Assumes the low-bit field is narrower than the shift amount.
module hb_io_xlate #(
    parameter int WIN_LOG2 = 23,
    parameter int LO_W     = 5,
    parameter int SHIFT    = 7,
    parameter int FLAT_W   = 16
) (
    input  logic [31:0] off,
    input  logic        sparse,
    output logic [31:0] port
);
    localparam logic [31:0] LO_MASK   = (32'h1 << LO_W) - 32'h1;
    localparam logic [31:0] HI_MASK   = ((32'h1 << (WIN_LOG2 - SHIFT)) - 32'h1) & ~LO_MASK;
    localparam logic [31:0] FLAT_MASK = (32'h1 << FLAT_W) - 32'h1;
    localparam logic [31:0] WIN_SIZE  = 32'h1 << WIN_LOG2;

    // Choose raw, sparse or flat translation.
    always_comb begin
        if (off >= WIN_SIZE)
            port = off;
        else if (sparse)
            port = ((off >> SHIFT) & HI_MASK) | (off & LO_MASK);
        else
            port = off & FLAT_MASK;
    end
endmodule

// File: rtl/hb_cfg_xlate.sv
`timescale 1ns/1ps
// Builds a type-0 configuration address from a window offset. The lowest
// set bit of the select field gives the device number. If no bit is set,
// the number is the field width.
module hb_cfg_xlate #(
    parameter int SEL_LO = 11,
    parameter int SEL_N  = 11,
    parameter int OFF_W  = 22
) (
    input  logic [OFF_W-1:0] off,
    output logic [31:0]      cfg_addr
);
    localparam int DEV_W = $clog2(SEL_N + 1);

    logic [DEV_W-1:0] dev;
    logic             found;

    // Upward scan for the first set select bit.
    always_comb begin
        dev   = DEV_W'(SEL_N);
        found = 1'b0;
        for (int i = 0; i < SEL_N; i++) begin
            if (!found && off[SEL_LO + i]) begin
                dev   = DEV_W'(i);
                found = 1'b1;
            end
        end
    end

    // Join device number and register offset.
    always_comb begin
        cfg_addr = (32'(dev) << SEL_LO) | 32'(off[SEL_LO-1:0]);
    end
endmodule

// File: rtl/hb_cfg_index_reg.sv
`timescale 1ns/1ps
// 32-bit configuration index register with little-endian byte lanes.
// Lanes that would go past byte 3 are dropped on both read and write.
module hb_cfg_index_reg
    import hb_dec_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           lane,
    input  logic [1:0]           size,
    input  logic [8*BYTES-1:0]   wdata,
    output logic [8*BYTES-1:0]   idx_q,
    output logic [8*BYTES-1:0]   rdata
);
    localparam int W = 8 * BYTES;

    logic [BYTES-1:0] nb_mask;
    logic [BYTES-1:0] lane_mask;
    logic [W-1:0]     wsh;
    logic [W-1:0]     rd_mask;

    // Byte-count mask from the size code.
    always_comb begin
        case (size)
            SZ_BYTE: nb_mask = BYTES'(4'b0001);
            SZ_HALF: nb_mask = BYTES'(4'b0011);
            default: nb_mask = BYTES'(4'b1111);
        endcase
        lane_mask = BYTES'(nb_mask << lane);
        wsh       = W'(wdata << {lane, 3'b000});
    end

    genvar k;
    generate
        for (k = 0; k < BYTES; k++) begin : g_lane
            // Byte k of the index register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    idx_q[8*k +: 8] <= 8'h00;
                else if (wr_en && lane_mask[k])
                    idx_q[8*k +: 8] <= wsh[8*k +: 8];
            end
            assign rd_mask[8*k +: 8] = {8{nb_mask[k]}};
        end
    endgenerate

    assign rdata = (idx_q >> {lane, 3'b000}) & rd_mask;
endmodule

// File: rtl/hb_addr_decoder.sv
`timescale 1ns/1ps
// Top of the host-bridge CPU address decoder. It registers one response
// per request, holds the I/O mode latched on idle edges, and owns the
// configuration index register. It assumes one request per cycle at most.
module hb_addr_decoder
    import hb_dec_pkg::*;
#(
    parameter logic [31:0] IO_BASE   = 32'h8000_0000,
    parameter logic [31:0] IO_SIZE   = 32'h3F80_0000,
    parameter logic [31:0] CFG_BASE  = 32'h8080_0000,
    parameter int          CFG_LOG2  = 22,
    parameter logic [31:0] MEM_BASE  = 32'hC000_0000,
    parameter logic [31:0] MEM_SIZE  = 32'h3F00_0000,
    parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0,
    parameter int          ROM_LOG2  = 20,
    parameter int          SEL_LO    = 11,
    parameter int          SEL_N     = 11,
    parameter logic [31:0] IDX_PORT  = 32'h0000_0CF8,
    parameter logic [31:0] DATA_PORT = 32'h0000_0CFC
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    input  logic        io_mode,
    output logic        rsp_valid,
    output logic [2:0]  rsp_region,
    output logic [31:0] rsp_addr,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata
);
    region_e     cls;
    logic [31:0] off;
    logic [31:0] io_port;
    logic [31:0] cfg_addr;
    logic [31:0] idx_q;
    logic [31:0] idx_rd;
    logic        mode_q;
    logic        idx_we;
    region_e     nxt_region;
    logic [31:0] nxt_addr;
    logic        nxt_err;
    logic [31:0] nxt_rdata;

    hb_region_classify #(
        .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE), .CFG_BASE(CFG_BASE),
        .CFG_LOG2(CFG_LOG2), .MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE),
        .IACK_ADDR(IACK_ADDR), .ROM_LOG2(ROM_LOG2)
    ) u_cls (
        .addr (req_addr),
        .cls  (cls),
        .off  (off)
    );

    hb_io_xlate u_io (
        .off    (off),
        .sparse (mode_q),
        .port   (io_port)
    );

    hb_cfg_xlate #(.SEL_LO(SEL_LO), .SEL_N(SEL_N), .OFF_W(CFG_LOG2)) u_cfg (
        .off      (off[CFG_LOG2-1:0]),
        .cfg_addr (cfg_addr)
    );

    hb_cfg_index_reg u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (idx_we),
        .lane  (io_port[1:0]),
        .size  (req_size),
        .wdata (req_wdata),
        .idx_q (idx_q),
        .rdata (idx_rd)
    );

    // Final region, address, error and read data for the current request.
    always_comb begin
        nxt_region = RGN_NONE;
        nxt_addr   = 32'h0;
        nxt_err    = 1'b0;
        nxt_rdata  = 32'h0;
        idx_we     = 1'b0;
        if (req_size == SZ_BAD) begin
            nxt_err = 1'b1;
        end else begin
            case (cls)
                RGN_IO: begin
                    if (io_port[31:2] == IDX_PORT[31:2]) begin
                        nxt_region = RGN_CFGIDX;
                        nxt_addr   = io_port;
                        nxt_rdata  = req_write ? 32'h0 : idx_rd;
                        idx_we     = req_valid && req_write;
                    end else if (io_port[31:2] == DATA_PORT[31:2]) begin
                        nxt_region = RGN_CFGDATA;
                        nxt_addr   = {idx_q[31:2], io_port[1:0]};
                    end else begin
                        nxt_region = RGN_IO;
                        nxt_addr   = io_port;
                    end
                end
                RGN_CFG: begin
                    nxt_region = RGN_CFG;
                    nxt_addr   = cfg_addr;
                end
                RGN_MEM, RGN_ROM: begin
                    nxt_region = cls;
                    nxt_addr   = off;
                end
                RGN_IACK: begin
                    if (!req_write) begin
                        if (req_size == SZ_BYTE) nxt_region = RGN_IACK;
                        else                     nxt_err    = 1'b1;
                    end
                end
                default: nxt_err = 1'b1;
            endcase
        end
        if (nxt_err) begin
            nxt_region = RGN_NONE;
            nxt_addr   = 32'h0;
            nxt_rdata  = 32'hFFFF_FFFF;
        end
    end

    // Latch the I/O scheme only when no request is presented.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= 1'b0;
        else if (!req_valid) mode_q <= io_mode;
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_region <= 3'd0;
            rsp_addr   <= 32'h0;
            rsp_err    <= 1'b0;
            rsp_rdata  <= 32'h0;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_region <= nxt_region;
            rsp_addr   <= nxt_addr;
            rsp_err    <= nxt_err;
            rsp_rdata  <= nxt_rdata;
        end
    end
endmodule

// File: rtl/hb_addr_decoder_chk.sv
`timescale 1ns/1ps
// Property checker for the address decoder, bound to every instance.
module hb_addr_decoder_chk #(
    parameter int ROM_LOG2 = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        mode_q,
    input logic        rsp_valid,
    input logic [2:0]  rsp_region,
    input logic [31:0] rsp_addr,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata
);
    // R12
    err_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'hFFFF_FFFF && rsp_region == 3'd0 && rsp_valid));
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_region == 3'd0 && !rsp_err));
    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid)) |-> $stable(mode_q));
    // R8
    rom_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_region == 3'd5) |-> ((rsp_addr >> ROM_LOG2) == 32'h0));
    // R3
    cfg_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_region == 3'd2) |-> (rsp_addr[31:15] == 17'h0 && rsp_addr[14:11] <= 4'd11));
    // R9
    iack_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_region == 3'd4) |-> (rsp_addr == 32'h0));
endmodule

bind hb_addr_decoder hb_addr_decoder_chk #(.ROM_LOG2(ROM_LOG2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .mode_q     (mode_q),
    .rsp_valid  (rsp_valid),
    .rsp_region (rsp_region),
    .rsp_addr   (rsp_addr),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/hb_addr_decoder_bench.sv
`timescale 1ns/1ps
module hb_addr_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_wdata = 32'h0;
    logic        io_mode = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_region;
    logic [31:0] rsp_addr;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic        mode_m = 1'b0;
    logic [31:0] idx_m = 32'h0;

    always #2 clk = ~clk;

    hb_addr_decoder u_hb_addr_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .io_mode(io_mode), .rsp_valid(rsp_valid), .rsp_region(rsp_region),
        .rsp_addr(rsp_addr), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic ev, input logic [2:0] er,
                         input logic [31:0] ea, input logic ee, input logic [31:0] ed);
        n_vec++;
        if (rsp_valid !== ev || rsp_region !== er || rsp_addr !== ea ||
            rsp_err !== ee || rsp_rdata !== ed) begin
            n_bad++;
            $display("FAIL %s: got v=%0b r=%0d a=%h e=%0b d=%h, expected v=%0b r=%0d a=%h e=%0b d=%h",
                     tag, rsp_valid, rsp_region, rsp_addr, rsp_err, rsp_rdata,
                     ev, er, ea, ee, ed);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // Expected response from the requirements, plus index update.
    task automatic model(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [2:0] er,
                         output logic [31:0] ea, output logic ee,
                         output logic [31:0] ed, output string tag);
        logic [31:0] o, t;
        int dev, ln;
        er = 3'd0; ea = 32'h0; ee = 1'b0; ed = 32'h0; tag = "R12";
        if (sz == 2'd3) begin
            ee = 1'b1;
        end else if (a >= 32'h8080_0000 && a <= 32'h80BF_FFFF) begin
            tag = "R3"; dev = 11;
            for (int i = 10; i >= 0; i--) if (a[11 + i]) dev = i;
            er = 3'd2; ea = (dev << 11) | {21'h0, a[10:0]};
        end else if (a >= 32'h8000_0000 && a <= 32'hBF7F_FFFF) begin
            o = a - 32'h8000_0000;
            if (o >= 32'h0080_0000) begin t = o; tag = "R5"; end
            else if (mode_m) begin t = {16'h0, o[22:12], o[4:0]}; tag = "R5"; end
            else begin t = {16'h0, o[15:0]}; tag = "R4"; end
            if (t[31:2] == 30'h33E) begin
                tag = "R10"; er = 3'd7; ea = t; ln = int'(t[1:0]);
                for (int k = 0; k < nbytes(sz); k++) begin
                    if (ln + k < 4) begin
                        if (wr) idx_m[8*(ln+k) +: 8] = wd[8*k +: 8];
                        else    ed[8*k +: 8] = idx_m[8*(ln+k) +: 8];
                    end
                end
            end else if (t[31:2] == 30'h33F) begin
                tag = "R11"; er = 3'd6; ea = {idx_m[31:2], t[1:0]};
            end else begin
                er = 3'd1; ea = t;
            end
        end else if (a == 32'hBFFF_FFF0) begin
            tag = "R9";
            if (!wr) begin
                if (sz == 2'd0) er = 3'd4;
                else ee = 1'b1;
            end
        end else if (a >= 32'hC000_0000 && a <= 32'hFEFF_FFFF) begin
            tag = "R7"; er = 3'd3; ea = a - 32'hC000_0000;
        end else if (a >= 32'hFFF0_0000) begin
            tag = "R8"; er = 3'd5; ea = a - 32'hFFF0_0000;
        end else begin
            ee = 1'b1;
        end
        if (ee) begin er = 3'd0; ea = 32'h0; ed = 32'hFFFF_FFFF; end
    endtask

    // One request, checked just after the edge that registers it.
    task automatic acc(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                       input logic [31:0] wd);
        logic [2:0] er; logic [31:0] ea, ed; logic ee; string tag;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_wdata = wd;
        model(a, wr, sz, wd, er, ea, ee, ed, tag);
        @(posedge clk); #1;
        check(tag, 1'b1, er, ea, ee, ed);
    endtask

    // One idle edge: latches the mode and gives a quiet response.
    task automatic idle(input logic m);
        req_valid = 1'b0; io_mode = m;
        @(posedge clk); #1;
        mode_m = m;
        check("R2", 1'b0, 3'd0, 32'h0, 1'b0, 32'h0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check("R1", 1'b0, 3'd0, 32'h0, 1'b0, 32'h0);
        rst_n = 1'b1;
        idle(1'b0);
        // R1: index starts at zero; data port shows it
        acc(32'h8000_0CF8, 1'b0, 2'd2, 32'h0);
        acc(32'h8000_0CFD, 1'b0, 2'd0, 32'h0);
        // R3 corner cases
        acc(32'h8080_0123, 1'b0, 2'd0, 32'h0);
        acc(32'h80A0_0000, 1'b0, 2'd2, 32'h0);
        acc(32'h8090_2004, 1'b1, 2'd1, 32'h0);
        acc(32'h80BF_FFFF, 1'b0, 2'd0, 32'h0);
        acc(32'h80C0_0000, 1'b0, 2'd0, 32'h0);
        // R4 / R5 edges of I/O space
        acc(32'h8001_2345, 1'b0, 2'd1, 32'h0);
        acc(32'hBF7F_FFFF, 1'b0, 2'd0, 32'h0);
        acc(32'hBF80_0000, 1'b0, 2'd0, 32'h0);
        // R9 interrupt acknowledge
        acc(32'hBFFF_FFF0, 1'b0, 2'd0, 32'h0);
        acc(32'hBFFF_FFF0, 1'b0, 2'd1, 32'h0);
        acc(32'hBFFF_FFF0, 1'b1, 2'd0, 32'h55);
        // R7 / R8 / R12 boundaries
        acc(32'hC000_0000, 1'b0, 2'd2, 32'h0);
        acc(32'hFEFF_FFFF, 1'b0, 2'd2, 32'h0);
        acc(32'hFF00_0000, 1'b0, 2'd2, 32'h0);
        acc(32'hFFF0_0000, 1'b0, 2'd2, 32'h0);
        acc(32'hFFFF_FFFF, 1'b0, 2'd0, 32'h0);
        acc(32'h7FFF_FFFF, 1'b0, 2'd0, 32'h0);
        acc(32'hC000_0000, 1'b0, 2'd3, 32'h0);
        // R10 then R11 back to back: data port must see new index
        acc(32'h8000_0CF8, 1'b1, 2'd2, 32'h1234_5678);
        acc(32'h8000_0CFE, 1'b0, 2'd1, 32'h0);
        acc(32'h8000_0CF9, 1'b0, 2'd0, 32'h0);
        acc(32'h8000_0CFA, 1'b1, 2'd2, 32'hAABB_CCDD);
        acc(32'h8000_0CF8, 1'b0, 2'd2, 32'h0);
        // R6: mode flips mid-burst, applies only after an idle edge
        idle(1'b0);
        acc(32'h8006_7018, 1'b0, 2'd0, 32'h0);
        io_mode = 1'b1;
        acc(32'h8006_7019, 1'b0, 2'd0, 32'h0);
        acc(32'h8006_7FFF, 1'b0, 2'd0, 32'h0);
        idle(1'b1);
        acc(32'h8006_7018, 1'b1, 2'd2, 32'hCAFE_F00D);
        acc(32'h8006_701C, 1'b0, 2'd0, 32'h0);
        acc(32'h807F_FFFF, 1'b0, 2'd0, 32'h0);
        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 10 == 0) idle(1'($urandom % 2));
            case ($urandom % 8)
                0: a = 32'h8000_0000 + ($urandom % 32'h0080_0000);
                1: a = 32'h80C0_0000 + ($urandom % 32'h3EC0_0000);
                2: a = 32'h8080_0000 + ($urandom % 32'h0040_0000);
                3: a = 32'hC000_0000 + ($urandom % 32'h3F00_0000);
                4: a = 32'hFFF0_0000 + ($urandom % 32'h0010_0000);
                5: a = $urandom;
                6: a = (($urandom % 2) ? 32'h8006_7018 : 32'h8000_0CF8) + ($urandom % 8);
                default: a = 32'hBFFF_FFF0;
            endcase
            acc(a, 1'($urandom % 2),
                ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3), $urandom);
        end
        idle(1'b0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule